// File: doc/BRIEF.md
# Parallel Bit-Error Checker with Pattern Lock

This block sits behind a deserializer that delivers a 512-bit word on every low-rate clock. It rebuilds the expected test sequence locally, locks that reference to the incoming stream, and then counts every bit that differs. The sequence is either a pseudo-random binary sequence of a selectable order or a short programmed pattern held in an internal memory.

The word can be checked in two ways. In combined mode it is one 512-bit slice of a single stream. In split mode it is four independent 128-bit lanes, and each lane may carry its own sequence. Every engine keeps its own lock state and its own counters:
- bit errors seen while locked;
- bits compared while locked;
- clock cycles spent out of lock.

A measurement gate decides when counting happens. Its rising edge restarts all counters. A host reads any counter through a small select-and-read port.

Top module: `bert_checker`

## Requirements
- R1: In combined mode (`cfg_comb`=1) the whole word is one stream slice. Bit 0 is the earliest bit in time and bit 511 the latest. The per-word error count is the number of set bits in the XOR of the expected and received words.
- R2: In split mode (`cfg_comb`=0) lane k is `din[128k+127:128k]`. Each lane uses its own pattern select `cfg_pat_lane[3k+2:3k]` and keeps its own lock state and counters.
- R3: A sequence engine that is not locked seeds its 31-bit history from the tail of each received word. It declares lock after `cfg_lock_n` consecutive words with zero errors, and the lock is visible on the next cycle.
- R4: When a locked engine sees a word with more errors than `cfg_loss_thr`, it drops lock on the next cycle and re-enters acquisition. An error count exactly equal to the threshold keeps the lock. The word that causes the loss is still counted.
- R5: The per-word error count is added to that engine's error counter only in a cycle where the engine is locked and `gate`=1.
- R6: The out-of-lock counter of an engine advances by one in each cycle where the engine is enabled, not locked and `gate`=1.
- R7: The compared-bit counter advances by the engine width (512 or 128) in each locked cycle with `gate`=1.
- R8: Every counter saturates at its all-ones value instead of wrapping.
- R9: With pattern select 7 the engine compares against its programmed memory. While acquiring, it moves its read pointer only on an error-free word, so the alignment slides by one word per mismatch until `cfg_lock_n` clean words are seen.
- R10: A rising edge of `gate` clears all counters before that cycle's contribution is added. While `gate`=0 the counters hold their values.
- R11: `rd_eng` 0 to 3 selects a lane and 4 selects the combined engine; any other value reads 0. `rd_sel` 0 reads errors, 1 reads compared bits, 2 reads out-of-lock cycles and 3 reads the lock flag in bit 0.
- R12: Pattern select codes 0 to 6 give the recurrences s[k]=s[k-n]^s[k-m] with (n,m) equal to (7,6), (9,5), (10,7), (11,9), (15,14), (23,18) and (31,28). Code 7 is the programmed pattern.
- R13: An engine that the mode does not use (the lanes in combined mode, the combined engine in split mode) is held out of lock and never counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_comb | input | 1 | 1 = combined mode, 0 = four-lane split mode |
| cfg_pat_comb | input | 3 | Pattern select of the combined engine |
| cfg_pat_lane | input | 12 | Pattern selects of the four lanes, 3 bits each |
| cfg_lock_n | input | 4 | Clean words needed to declare lock |
| cfg_loss_thr | input | 10 | Per-word error count above which lock is lost |
| gate | input | 1 | Measurement gate |
| din | input | 512 | Received word |
| pat_we | input | 1 | Programmed-pattern memory write strobe |
| pat_eng | input | 3 | Engine whose memory is written (0 to 3 lanes, 4 combined) |
| pat_addr | input | 2 | Memory word address |
| pat_wdata | input | 512 | Memory word; lanes take the low 128 bits |
| rd_eng | input | 3 | Engine selected for reading |
| rd_sel | input | 2 | Counter selected for reading |
| rd_data | output | 48 | Selected counter value |

## Verification
The assertions assume the following about the inputs:
- Configuration and mode change only between words, synchronously to the clock.
- `cfg_lock_n` is at least 1.
- The programmed memory of an engine is loaded before that engine selects code 7.

The stimulus respects these assumptions in three ways. Every input changes on the falling edge. The pattern memory of lane 3 is filled while the block is in combined mode, so no lane reads it yet. Errors are injected only in chosen bit positions, so the 31-bit history that follows a loss stays clean. A behavioural model in the bench recomputes each engine's state and counters by bit-serial means and is compared with all twenty readable values after every clock.

// File: rtl/bert_pkg.sv
package bert_pkg;
  localparam int HIST_W = 31;

  typedef enum logic [2:0] {
    PAT_S7 = 3'd0, PAT_S9 = 3'd1, PAT_S10 = 3'd2, PAT_S11 = 3'd3,
    PAT_S15 = 3'd4, PAT_S23 = 3'd5, PAT_S31 = 3'd6, PAT_PROG = 3'd7
  } pat_e;

  // Longer feedback lag of each recurrence (R12)
  function automatic int tap_long(input logic [2:0] sel);
    case (sel)
      3'd0: return 7;
      3'd1: return 9;
      3'd2: return 10;
      3'd3: return 11;
      3'd4: return 15;
      3'd5: return 23;
      3'd6: return 31;
      default: return 7;
    endcase
  endfunction

  // Shorter feedback lag of each recurrence (R12)
  function automatic int tap_short(input logic [2:0] sel);
    case (sel)
      3'd0: return 6;
      3'd1: return 5;
      3'd2: return 7;
      3'd3: return 9;
      3'd4: return 14;
      3'd5: return 18;
      3'd6: return 28;
      default: return 6;
    endcase
  endfunction
endpackage

// File: rtl/bert_sat_counter.sv
module bert_sat_counter #(
  parameter int WIDTH = 48,
  parameter int IW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [IW-1:0]    add,
  output logic [WIDTH-1:0] cnt
);
  logic [WIDTH-1:0] base;
  logic [WIDTH:0]   sum;

  assign base = clr ? '0 : cnt;
  assign sum  = {1'b0, base} + {{(WIDTH+1-IW){1'b0}}, add};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (add_en) cnt <= sum[WIDTH] ? '1 : sum[WIDTH-1:0];
    else             cnt <= base;
  end

  // R8: a counter never goes backwards unless cleared
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> cnt >= $past(cnt));
  // R10: no clear and no increment leaves the count unchanged
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_en) |=> $stable(cnt));
endmodule

// File: rtl/bert_lane_engine.sv
module bert_lane_engine
  import bert_pkg::*;
#(
  parameter int W       = 128,
  parameter int DEPTH   = 4,
  parameter int LOCKN_W = 4,
  parameter int THR_W   = 10,
  parameter int ERR_W   = 48,
  parameter int TIME_W  = 32,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(W+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               gate,
  input  logic               gate_rise,
  input  logic [2:0]         pat_sel,
  input  logic [LOCKN_W-1:0] lock_n,
  input  logic [THR_W-1:0]   loss_thr,
  input  logic [W-1:0]       din,
  input  logic               pat_we,
  input  logic [AW-1:0]      pat_addr,
  input  logic [W-1:0]       pat_wdata,
  output logic               locked,
  output logic [ERR_W-1:0]   err_cnt,
  output logic [ERR_W-1:0]   bit_cnt,
  output logic [TIME_W-1:0]  unl_cnt
);
  logic [HIST_W-1:0]  hist;
  logic [W-1:0]       mem [DEPTH];
  logic [AW-1:0]      ptr;
  logic [LOCKN_W-1:0] good;

  // Extend the history by W bits of the selected recurrence; index 0 is oldest
  function automatic logic [W-1:0] prbs_next(input logic [HIST_W-1:0] h,
                                             input logic [2:0] sel);
    logic [W+HIST_W-1:0] x;
    int n, m;
    n = tap_long(sel);
    m = tap_short(sel);
    x = '0;
    x[HIST_W-1:0] = h;
    for (int k = 0; k < W; k++) x[HIST_W+k] = x[HIST_W+k-n] ^ x[HIST_W+k-m];
    return x[W+HIST_W-1:HIST_W];
  endfunction

  function automatic logic [CW-1:0] popcnt(input logic [W-1:0] v);
    logic [CW-1:0] c;
    c = '0;
    for (int i = 0; i < W; i++) c = c + CW'(v[i]);
    return c;
  endfunction

  logic [W-1:0]     exp_word;
  logic [CW-1:0]    word_err;
  logic [THR_W-1:0] err_wide;
  logic             is_prog, clean, lock_ev, loss_ev, keep_ref, adv;

  assign is_prog  = (pat_sel == PAT_PROG);
  assign exp_word = is_prog ? mem[ptr] : prbs_next(hist, pat_sel);
  assign word_err = popcnt(exp_word ^ din);
  assign err_wide = THR_W'(word_err);
  assign clean    = en && !locked && (word_err == '0);
  assign lock_ev  = clean && (({1'b0, good} + (LOCKN_W+1)'(1)) >= {1'b0, lock_n});
  assign loss_ev  = en && locked && (err_wide > loss_thr);
  assign keep_ref = en && locked && !loss_ev;
  assign adv      = en && is_prog && (locked ? !loss_ev : clean);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      good   <= '0;
      ptr    <= '0;
      hist   <= '0;
    end else begin
      locked <= en && (locked ? !loss_ev : lock_ev);
      good   <= (clean && !lock_ev) ? good + LOCKN_W'(1) : '0;
      if (adv) ptr <= (ptr == AW'(DEPTH-1)) ? '0 : ptr + AW'(1);
      hist   <= keep_ref ? exp_word[W-1 -: HIST_W] : din[W-1 -: HIST_W];
    end
  end

  always_ff @(posedge clk) begin
    if (pat_we) mem[pat_addr] <= pat_wdata;
  end

  bert_sat_counter #(.WIDTH(ERR_W), .IW(CW)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(gate_rise),
    .add_en(en && gate && locked), .add(word_err), .cnt(err_cnt));

  bert_sat_counter #(.WIDTH(ERR_W), .IW(CW)) u_bits (
    .clk(clk), .rst_n(rst_n), .clr(gate_rise),
    .add_en(en && gate && locked), .add(CW'(W)), .cnt(bit_cnt));

  bert_sat_counter #(.WIDTH(TIME_W), .IW(1)) u_unl (
    .clk(clk), .rst_n(rst_n), .clr(gate_rise),
    .add_en(en && gate && !locked), .add(1'b1), .cnt(unl_cnt));

  // R3: lock only follows an error-free word
  p_lock_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(word_err) == '0);
  // R4: a loss event removes lock on the next cycle
  p_loss_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loss_ev |=> !locked);
  // R13: a disabled engine is held out of lock
  p_idle_unlocked_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !locked);
endmodule

// File: rtl/bert_checker.sv
module bert_checker
  import bert_pkg::*;
#(
  parameter int LANES   = 4,
  parameter int LANE_W  = 128,
  parameter int DEPTH   = 4,
  parameter int LOCKN_W = 4,
  parameter int ERR_W   = 48,
  parameter int TIME_W  = 32,
  localparam int W      = LANES * LANE_W,
  localparam int NENG   = LANES + 1,
  localparam int EI_W   = $clog2(NENG),
  localparam int AW     = $clog2(DEPTH),
  localparam int THR_W  = $clog2(W+1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_comb,
  input  logic [2:0]         cfg_pat_comb,
  input  logic [3*LANES-1:0] cfg_pat_lane,
  input  logic [LOCKN_W-1:0] cfg_lock_n,
  input  logic [THR_W-1:0]   cfg_loss_thr,
  input  logic               gate,
  input  logic [W-1:0]       din,
  input  logic               pat_we,
  input  logic [EI_W-1:0]    pat_eng,
  input  logic [AW-1:0]      pat_addr,
  input  logic [W-1:0]       pat_wdata,
  input  logic [EI_W-1:0]    rd_eng,
  input  logic [1:0]         rd_sel,
  output logic [ERR_W-1:0]   rd_data
);
  logic gate_q, gate_rise;
  logic [NENG-1:0]   lk;
  logic [ERR_W-1:0]  err_a  [NENG];
  logic [ERR_W-1:0]  bits_a [NENG];
  logic [TIME_W-1:0] unl_a  [NENG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end
  assign gate_rise = gate && !gate_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bert_lane_engine #(
      .W(LANE_W), .DEPTH(DEPTH), .LOCKN_W(LOCKN_W), .THR_W(THR_W),
      .ERR_W(ERR_W), .TIME_W(TIME_W)
    ) u_eng (
      .clk(clk), .rst_n(rst_n), .en(!cfg_comb), .gate(gate), .gate_rise(gate_rise),
      .pat_sel(cfg_pat_lane[3*g +: 3]), .lock_n(cfg_lock_n), .loss_thr(cfg_loss_thr),
      .din(din[g*LANE_W +: LANE_W]),
      .pat_we(pat_we && (pat_eng == EI_W'(g))), .pat_addr(pat_addr),
      .pat_wdata(pat_wdata[LANE_W-1:0]),
      .locked(lk[g]), .err_cnt(err_a[g]), .bit_cnt(bits_a[g]), .unl_cnt(unl_a[g]));
  end

  bert_lane_engine #(
    .W(W), .DEPTH(DEPTH), .LOCKN_W(LOCKN_W), .THR_W(THR_W),
    .ERR_W(ERR_W), .TIME_W(TIME_W)
  ) u_comb (
    .clk(clk), .rst_n(rst_n), .en(cfg_comb), .gate(gate), .gate_rise(gate_rise),
    .pat_sel(cfg_pat_comb), .lock_n(cfg_lock_n), .loss_thr(cfg_loss_thr),
    .din(din), .pat_we(pat_we && (pat_eng == EI_W'(LANES))), .pat_addr(pat_addr),
    .pat_wdata(pat_wdata),
    .locked(lk[LANES]), .err_cnt(err_a[LANES]), .bit_cnt(bits_a[LANES]),
    .unl_cnt(unl_a[LANES]));

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NENG; i++) begin
      if (rd_eng == EI_W'(i)) begin
        case (rd_sel)
          2'd0:    rd_data = err_a[i];
          2'd1:    rd_data = bits_a[i];
          2'd2:    rd_data = ERR_W'(unl_a[i]);
          default: rd_data = ERR_W'(lk[i]);
        endcase
      end
    end
  end

  // R13: the combined engine and the lanes are never locked together
  p_excl_lock_r13: assert property (@(posedge clk) disable iff (!rst_n)
    lk[LANES] |-> lk[LANES-1:0] == '0);
endmodule

// File: tb/sim_bert_checker.sv
module sim_bert_checker;
  localparam int PERIOD = 100;
  localparam int LW = 128;
  localparam int W  = 512;
  localparam int TW = 8;
  localparam int D  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic         cfg_comb = 1'b1;
  logic [2:0]   cfg_pat_comb = 3'd0;
  logic [11:0]  cfg_pat_lane = '0;
  logic [3:0]   cfg_lock_n = 4'd4;
  logic [9:0]   cfg_loss_thr = 10'd20;
  logic         gate = 1'b0;
  logic [511:0] din = '0;
  logic         pat_we = 1'b0;
  logic [2:0]   pat_eng = '0;
  logic [1:0]   pat_addr = '0;
  logic [511:0] pat_wdata = '0;
  logic [2:0]   rd_eng = '0;
  logic [1:0]   rd_sel = '0;
  logic [47:0]  rd_data;

  bert_checker #(.TIME_W(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_comb(cfg_comb), .cfg_pat_comb(cfg_pat_comb),
    .cfg_pat_lane(cfg_pat_lane), .cfg_lock_n(cfg_lock_n), .cfg_loss_thr(cfg_loss_thr),
    .gate(gate), .din(din), .pat_we(pat_we), .pat_eng(pat_eng), .pat_addr(pat_addr),
    .pat_wdata(pat_wdata), .rd_eng(rd_eng), .rd_sel(rd_sel), .rd_data(rd_data));

  int n_chk = 0;
  int n_bad = 0;

  // model state
  bit     mh [5][31];
  int     mlk [5], mgood [5], mptr [5];
  longint merr [5], mbits [5], munl [5];
  bit     gate_prev;
  bit [511:0] pm [5][D];
  // generator state
  bit     gh [5][31];
  int     gord [5], goff [5];
  bit     rnd [4];
  bit [511:0] inj;

  function automatic int lag_n(input int s);
    int t [7] = '{7, 9, 10, 11, 15, 23, 31};
    return t[s];
  endfunction
  function automatic int lag_m(input int s);
    int t [7] = '{6, 5, 7, 9, 14, 18, 28};
    return t[s];
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic rd(input int e, input int s, output longint v);
    rd_eng = 3'(e);
    rd_sel = 2'(s);
    #1;
    v = longint'(rd_data);
  endtask

  task automatic gen(input int g, input int width, output bit [511:0] w);
    w = '0;
    if (gord[g] == 7) begin
      w = pm[g][goff[g]];
      goff[g] = (goff[g] + 1) % D;
    end else begin
      for (int k = 0; k < width; k++) begin
        bit b;
        b = gh[g][31 - lag_n(gord[g])] ^ gh[g][31 - lag_m(gord[g])];
        for (int j = 0; j < 30; j++) gh[g][j] = gh[g][j+1];
        gh[g][30] = b;
        w[k] = b;
      end
    end
  endtask

  function automatic bit [511:0] predict(input int e, input int width, input int s);
    bit x [543];
    bit [511:0] r;
    r = '0;
    for (int j = 0; j < 31; j++) x[j] = mh[e][j];
    for (int k = 0; k < width; k++) begin
      x[31+k] = x[31+k-lag_n(s)] ^ x[31+k-lag_m(s)];
      r[k] = x[31+k];
    end
    return r;
  endfunction

  task automatic build_din();
    bit [511:0] w;
    din = '0;
    if (cfg_comb) begin
      gen(4, W, w);
      din = w;
    end else begin
      for (int l = 0; l < 4; l++) begin
        if (rnd[l]) w = {384'b0, $urandom, $urandom, $urandom, $urandom};
        else gen(l, LW, w);
        din[l*LW +: LW] = w[LW-1:0];
      end
    end
    din = din ^ inj;
    inj = '0;
  endtask

  task automatic model_step();
    bit rise;
    rise = gate && !gate_prev;
    for (int e = 0; e < 5; e++) begin
      int width, s, err;
      bit en;
      bit [511:0] rx, ex;
      bit keep;
      width = (e == 4) ? W : LW;
      en = (e == 4) ? cfg_comb : !cfg_comb;
      s = (e == 4) ? int'(cfg_pat_comb) : int'(cfg_pat_lane[3*e +: 3]);
      rx = (e == 4) ? din : {384'b0, din[e*LW +: LW]};
      ex = (s == 7) ? pm[e][mptr[e]] : predict(e, width, s);
      err = 0;
      for (int k = 0; k < width; k++) if (rx[k] != ex[k]) err++;
      if (rise) begin merr[e] = 0; mbits[e] = 0; munl[e] = 0; end
      if (gate && en) begin
        if (mlk[e] != 0) begin
          merr[e] += err;
          mbits[e] += width;
        end else if (munl[e] < (1 << TW) - 1) munl[e]++;
      end
      keep = 0;
      if (!en) begin
        mlk[e] = 0; mgood[e] = 0;
      end else if (mlk[e] != 0) begin
        if (err > int'(cfg_loss_thr)) begin
          mlk[e] = 0;
          mgood[e] = 0;
        end else begin
          keep = 1;
          if (s == 7) mptr[e] = (mptr[e] + 1) % D;
        end
      end else if (err == 0) begin
        if (s == 7) mptr[e] = (mptr[e] + 1) % D;
        if (mgood[e] + 1 >= int'(cfg_lock_n)) begin
          mlk[e] = 1;
          mgood[e] = 0;
        end else mgood[e]++;
      end else mgood[e] = 0;
      for (int j = 0; j < 31; j++) mh[e][j] = keep ? ex[width-31+j] : rx[width-31+j];
    end
    if (pat_we) begin
      if (pat_eng == 3'd4) pm[4][pat_addr] = pat_wdata;
      else pm[pat_eng][pat_addr] = {384'b0, pat_wdata[LW-1:0]};
    end
    gate_prev = gate;
  endtask

  task automatic compare_all();
    longint v;
    for (int e = 0; e < 5; e++) begin
      for (int s = 0; s < 4; s++) begin
        rd(e, s, v);
        case (s)
          0: chk("R5 error count", v, merr[e]);
          1: chk("R7 compared bits", v, mbits[e]);
          2: chk("R6 unlocked cycles", v, munl[e]);
          default: chk("R3 lock flag", v, longint'(mlk[e]));
        endcase
      end
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      build_din();
      cycle();
    end
  endtask

  initial begin
    longint v, keep_bits;
    inj = '0;
    for (int g = 0; g < 5; g++) begin
      for (int j = 0; j < 31; j++) begin gh[g][j] = 1'b1; mh[g][j] = 1'b0; end
      mlk[g] = 0; mgood[g] = 0; mptr[g] = 0;
      merr[g] = 0; mbits[g] = 0; munl[g] = 0; goff[g] = 0; gord[g] = 0;
      for (int a = 0; a < D; a++) pm[g][a] = '0;
    end
    for (int l = 0; l < 4; l++) rnd[l] = 0;
    gate_prev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all();
    rd(5, 0, v); chk("R11 unused engine reads zero", v, 0);

    // load lane 3 pattern memory while lanes are idle (combined mode, all-zero data)
    for (int a = 0; a < D; a++) begin
      pat_we = 1'b1; pat_eng = 3'd3; pat_addr = 2'(a);
      pat_wdata = {384'b0, $urandom, $urandom, $urandom, $urandom};
      din = '0;
      cycle();
    end
    pat_we = 1'b0;

    // split mode: four different patterns
    cfg_comb = 1'b0;
    cfg_pat_lane = {3'd7, 3'd6, 3'd4, 3'd0};
    gord[0] = 0; gord[1] = 4; gord[2] = 6; gord[3] = 7; goff[3] = 2;
    gate = 1'b1;
    run(12);
    for (int l = 0; l < 4; l++) begin
      rd(l, 3, v); chk("R2 lane locked independently", v, 1);
    end
    rd(3, 0, v); chk("R9 programmed pattern aligned with no errors", v, 0);
    rd(4, 3, v); chk("R13 combined engine idle in split mode", v, 0);

    // lane 0: errors equal to threshold; lane 2: one above
    for (int b = 0; b < 20; b++) inj[b] = 1'b1;
    for (int b = 0; b < 21; b++) inj[2*LW + b] = 1'b1;
    inj[LW + 5] = 1'b1;
    run(1);
    rd(0, 3, v); chk("R4 threshold-equal keeps lock", v, 1);
    rd(2, 3, v); chk("R4 above threshold drops lock", v, 0);
    inj[LW + 5] = 1'b1; run(1);
    inj[LW + 9] = 1'b1; run(1);
    run(8);
    rd(0, 0, v); chk("R4 lane 0 errors counted", v, 20);
    rd(1, 0, v); chk("R5 lane 1 single-bit errors", v, 3);
    rd(2, 3, v); chk("R4 lane 2 reacquired", v, 1);
    rd(2, 0, v); chk("R4 loss word counted", v, 21);

    // gate low freezes counters
    rd(1, 1, keep_bits);
    gate = 1'b0;
    inj[LW + 3] = 1'b1;
    run(5);
    rd(1, 0, v); chk("R10 frozen errors", v, 3);
    rd(1, 1, v); chk("R10 frozen bit count", v, keep_bits);
    gate = 1'b1;
    run(1);
    rd(1, 0, v); chk("R10 rise clears errors", v, 0);
    rd(1, 1, v); chk("R7 one locked word after clear", v, 128);

    // combined mode
    cfg_comb = 1'b1; cfg_pat_comb = 3'd5; gord[4] = 5;
    run(10);
    rd(4, 3, v); chk("R1 combined engine locked", v, 1);
    for (int l = 0; l < 4; l++) begin
      rd(l, 3, v); chk("R13 lanes idle in combined mode", v, 0);
    end
    rd(4, 0, keep_bits);
    inj[127] = 1'b1; inj[128] = 1'b1; inj[300] = 1'b1;
    run(3);
    rd(4, 0, v); chk("R1 errors across lane boundaries", v, keep_bits + 3);
    for (int s = 1; s <= 3; s++) begin
      cfg_pat_comb = 3'(s); gord[4] = s;
      run(12);
      rd(4, 3, v); chk("R12 pattern code locks", v, 1);
    end

    // lane 0 receives noise: out-of-lock counter saturates
    cfg_comb = 1'b0;
    rnd[0] = 1;
    run(300);
    rd(0, 2, v); chk("R8 unlocked counter saturates", v, (1 << TW) - 1);
    rd(0, 3, v); chk("R6 noisy lane unlocked", v, 0);
    for (int l = 1; l < 4; l++) begin
      rd(l, 3, v); chk("R2 other lanes unaffected", v, 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule